// File: doc/BRIEF.md
# Compare Timer Channel

A single 16-bit up-counting timer channel controlled over a byte-wide register bus. The counter advances on ticks from an internal prescaler (divide by 1, 4, 16 or 64). It counts only while this channel's bit in a start vector, shared with other channels, is set. Four 16-bit slots (A to D) each work either as a compare register or as a capture register. In compare mode a slot raises its flag when the counter reaches its value, can drive an output pin, and can be chosen as the event that returns the counter to zero. In capture mode a slot latches the counter on a chosen edge of its capture input.

Status flags stay set until software reads the status register and then writes 0 to the flag's bit. The interrupt line is active whenever a set flag has its enable bit set. A typical use is a periodic tick: slot A holds N, the clear source is slot A, and the counter wraps every N+1 prescaled ticks.

Top module: `cmp_timer_channel`

## Requirements
- R1: After reset every register reads 0, all four `cmp_pin` outputs are 0 and `irq` is 0.
- R2: Control bits [2:0] choose the tick rate: 0, 1, 2 and 3 divide `clk` by 1, 4, 16 and 64, and codes 4 to 7 produce no tick.
  - The counter advances once per tick, and only while `run_vec[CHAN_IDX]` is 1.
  - The prescaler restarts from zero whenever that bit is 0, so with divide-by-4 the first tick comes on the 4th running cycle.
- R3: A tick that moves the counter from 0xFFFF to 0 sets status bit 4 (overflow).
- R4: Control bits [7:5] choose the counter-clear source. 1 selects slot A, 2 slot B, 5 slot C and 6 slot D. Any other code means no clear. A tick on a clearing match loads 0 instead of incrementing, so the period is value+1 ticks.
- R5: A tick with a compare-mode slot equal to the counter sets that slot's status flag (bits 0 to 3 for A to D).
- R6: Status bits clear only when a 0 is written to a bit that was read as 1 by an earlier status read. Any status write ends that read's effect. Writing 1 leaves a bit unchanged, and a flag that is set in the same cycle stays set.
- R7: Slot action codes 8, 9 and 10 select capture on the rising, falling or either edge of `cap_in[i]`. The edge is judged against the previous cycle. A capture loads the current counter into the slot and sets its flag.
- R8: Slot action codes set the output pin as follows:
  - Writing codes 1, 2 or 3 drives the pin to 0. Writing codes 5, 6 or 7 drives it to 1.
  - On a match, code[1:0] = 1, 2 or 3 clears, sets or toggles the pin.
  - Codes 0, 4 and 11 to 15 leave the pin unchanged.
  - The code for A is at address 2 bits [3:0], for B at address 2 bits [7:4], for C at address 3 bits [3:0] and for D at address 3 bits [7:4].
- R9: `irq` equals the OR over bits 0 to 5 of (status AND interrupt enable). The enable register is at address 4.
- R10: Register map:
  - 0 is control, 1 is mode (storage only), 4 is interrupt enable and 5 is status.
  - The counter's high byte is at 6 and its low byte at 7.
  - Slot i's high byte is at 8+2i and its low byte at 9+2i.
  - A bus write to the counter takes priority over a tick in the same cycle, and a bus write to a slot takes priority over a capture.
- R11: Control bits [4:3] (count-edge select) have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_vec | input | RUN_W | Shared start vector; bit CHAN_IDX enables this channel |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (arms status clearing) |
| addr | input | 4 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| cap_in | input | 4 | Capture inputs for slots A to D |
| cmp_pin | output | 4 | Compare output pins for slots A to D |
| irq | output | 1 | Interrupt request |

## Verification
A register write is visible on `rdata` in the cycle after its clock edge, because `rdata` is a combinational decode of registered state. A tick acts at one edge: the new counter value, the match or overflow flag, the pin action and `irq` all appear after that same edge. A capture edge presented before an edge is latched at that edge. The reference model advances at each rising edge on the inputs held stable through it, and the outputs are compared on the falling edge, after both the model and the design have settled. Directed reads sample `rdata` before the edge at which the read takes effect, so the arming behaviour of R6 is exercised at exactly the cycle the design sees.

// File: rtl/cmp_timer_pkg.sv
`timescale 1ns/100ps
package cmp_timer_pkg;
   localparam int BYTE_W   = 8;
   localparam int NUM_SLOT = 4;
   localparam int FLAG_W   = 6;
   localparam int OVF_BIT  = 4;

   localparam logic [3:0] ADR_CTRL   = 4'd0;
   localparam logic [3:0] ADR_MODE   = 4'd1;
   localparam logic [3:0] ADR_IO_AB  = 4'd2;
   localparam logic [3:0] ADR_IO_CD  = 4'd3;
   localparam logic [3:0] ADR_IEN    = 4'd4;
   localparam logic [3:0] ADR_STAT   = 4'd5;
   localparam logic [3:0] ADR_CNT_HI = 4'd6;
   localparam logic [3:0] ADR_CNT_LO = 4'd7;
   localparam logic [3:0] ADR_SLOT0  = 4'd8;

   typedef enum logic [1:0] {PIN_KEEP, PIN_LOW, PIN_HIGH, PIN_FLIP} pin_act_e;

   function automatic logic is_capture(input logic [3:0] c);
      return (c == 4'd8) || (c == 4'd9) || (c == 4'd10);
   endfunction

   function automatic logic has_init(input logic [3:0] c);
      return !c[3] && (c[1:0] != 2'd0);
   endfunction

   function automatic pin_act_e match_action(input logic [3:0] c);
      if (has_init(c)) return pin_act_e'(c[1:0]);
      return PIN_KEEP;
   endfunction
endpackage

// File: rtl/cmp_timer_prescaler.sv
`timescale 1ns/100ps
module cmp_timer_prescaler #(
   parameter int PRE_W    = 6,
   parameter int NUM_TAPS = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [2:0] sel,
   output logic       tick
);
   localparam int MAX_TAPS = 4;

   if (PRE_W < 2 * (NUM_TAPS - 1)) begin : g_bad_width
      $error("prescaler counter too narrow for the highest tap");
   end
   if (NUM_TAPS < 1 || NUM_TAPS > MAX_TAPS) begin : g_bad_taps
      $error("NUM_TAPS must be 1..4");
   end

   logic [PRE_W-1:0]    pcnt_q;
   logic [MAX_TAPS-1:0] tap_hit;

   for (genvar t = 0; t < MAX_TAPS; t++) begin : g_tap
      if (t == 0) begin : g_div1
         assign tap_hit[t] = 1'b1;
      end else if (t < NUM_TAPS) begin : g_divn
         assign tap_hit[t] = &pcnt_q[2*t-1:0];
      end else begin : g_none
         assign tap_hit[t] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pcnt_q <= '0;
      else if (run) pcnt_q <= pcnt_q + 1'b1;
      else          pcnt_q <= '0;
   end

   assign tick = run && !sel[2] && tap_hit[sel[1:0]];
endmodule

// File: rtl/cmp_timer_slot.sv
`timescale 1ns/100ps
module cmp_timer_slot
   import cmp_timer_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        code,
   input  logic              code_wr,
   input  logic [3:0]        new_code,
   input  logic              tick,
   input  logic [WORD_W-1:0] cnt,
   input  logic              wr_hi,
   input  logic              wr_lo,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              cap_in,
   output logic [WORD_W-1:0] val,
   output logic              match,
   output logic              cap_ev,
   output logic              pin
);
   localparam int HALF = WORD_W / 2;

   if (WORD_W != 2 * BYTE_W) begin : g_bad_word
      $error("slot word must be two bus bytes");
   end

   logic [WORD_W-1:0] val_q;
   logic              prev_q;
   logic              pin_q;
   logic              rise, fall, cap_mode;

   assign cap_mode = is_capture(code);
   assign rise     = cap_in && !prev_q;
   assign fall     = !cap_in && prev_q;
   assign cap_ev   = ((code == 4'd8) && rise) || ((code == 4'd9) && fall)
                   || ((code == 4'd10) && (rise || fall));
   assign match    = tick && !cap_mode && (cnt == val_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q  <= '0;
         prev_q <= 1'b0;
         pin_q  <= 1'b0;
      end else begin
         prev_q <= cap_in;
         if (wr_hi) val_q[WORD_W-1:HALF] <= wdata;
         if (wr_lo) val_q[HALF-1:0]      <= wdata;
         if (!wr_hi && !wr_lo && cap_ev) val_q <= cnt;
         if (code_wr) begin
            if (has_init(new_code)) pin_q <= new_code[2];
         end else if (match) begin
            case (match_action(code))
               PIN_LOW:  pin_q <= 1'b0;
               PIN_HIGH: pin_q <= 1'b1;
               PIN_FLIP: pin_q <= !pin_q;
               default:  pin_q <= pin_q;
            endcase
         end
      end
   end

   assign val = val_q;
   assign pin = pin_q;

   a_r7_capture_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_ev && !wr_hi && !wr_lo) |=> (val_q == $past(cnt)));
   a_r8_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!code_wr && !match) |=> $stable(pin_q));
endmodule

// File: rtl/cmp_timer_channel.sv
`timescale 1ns/100ps
module cmp_timer_channel
   import cmp_timer_pkg::*;
#(
   parameter int RUN_W      = 8,
   parameter int CHAN_IDX   = 0,
   parameter int PRE_W      = 6,
   parameter int CAP_STAGES = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [RUN_W-1:0]    run_vec,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [3:0]          addr,
   input  logic [BYTE_W-1:0]   wdata,
   output logic [BYTE_W-1:0]   rdata,
   input  logic [NUM_SLOT-1:0] cap_in,
   output logic [NUM_SLOT-1:0] cmp_pin,
   output logic                irq
);
   localparam int WORD_W = 2 * BYTE_W;

   if (CHAN_IDX < 0 || CHAN_IDX >= RUN_W) begin : g_bad_idx
      $error("CHAN_IDX outside the start vector");
   end
   if (CAP_STAGES < 0) begin : g_bad_sync
      $error("CAP_STAGES must not be negative");
   end

   logic [BYTE_W-1:0]   ctrl_q, mode_q, io_ab_q, io_cd_q, ien_q;
   logic [FLAG_W-1:0]   status_q, armed_q, flag_set, flag_clr;
   logic [WORD_W-1:0]   cnt_q;
   logic [WORD_W-1:0]   slot_val [NUM_SLOT];
   logic [NUM_SLOT-1:0] match, cap_ev, cap_s;
   logic                run, tick, clr_hit, cnt_wr, stat_wr, stat_rd, ovf_ev;

   assign run     = run_vec[CHAN_IDX];
   assign cnt_wr  = wr_en && (addr == ADR_CNT_HI || addr == ADR_CNT_LO);
   assign stat_wr = wr_en && (addr == ADR_STAT);
   assign stat_rd = rd_en && !wr_en && (addr == ADR_STAT);

   if (CAP_STAGES == 0) begin : g_cap_direct
      assign cap_s = cap_in;
   end else begin : g_cap_sync
      logic [NUM_SLOT-1:0] sync_q [CAP_STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < CAP_STAGES; s++) sync_q[s] <= '0;
         end else begin
            sync_q[0] <= cap_in;
            for (int s = 1; s < CAP_STAGES; s++) sync_q[s] <= sync_q[s-1];
         end
      end
      assign cap_s = sync_q[CAP_STAGES-1];
   end

   cmp_timer_prescaler #(.PRE_W(PRE_W), .NUM_TAPS(4)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run), .sel(ctrl_q[2:0]), .tick(tick));

   for (genvar i = 0; i < NUM_SLOT; i++) begin : g_slot
      localparam logic [3:0] IO_ADR  = (i < 2) ? ADR_IO_AB : ADR_IO_CD;
      localparam logic [3:0] HI_ADR  = ADR_SLOT0 + 4'(2 * i);
      localparam logic [3:0] LO_ADR  = ADR_SLOT0 + 4'(2 * i + 1);
      logic [3:0] code, new_code;
      logic       code_wr;
      if (i % 2 == 0) begin : g_low_nib
         assign code     = (i < 2) ? io_ab_q[3:0] : io_cd_q[3:0];
         assign new_code = wdata[3:0];
      end else begin : g_high_nib
         assign code     = (i < 2) ? io_ab_q[7:4] : io_cd_q[7:4];
         assign new_code = wdata[7:4];
      end
      assign code_wr = wr_en && (addr == IO_ADR);

      cmp_timer_slot #(.WORD_W(WORD_W)) u_slot (
         .clk(clk), .rst_n(rst_n), .code(code), .code_wr(code_wr),
         .new_code(new_code), .tick(tick), .cnt(cnt_q),
         .wr_hi(wr_en && (addr == HI_ADR)), .wr_lo(wr_en && (addr == LO_ADR)),
         .wdata(wdata), .cap_in(cap_s[i]), .val(slot_val[i]),
         .match(match[i]), .cap_ev(cap_ev[i]), .pin(cmp_pin[i]));
   end

   always_comb begin
      case (ctrl_q[7:5])
         3'd1:    clr_hit = match[0];
         3'd2:    clr_hit = match[1];
         3'd5:    clr_hit = match[2];
         3'd6:    clr_hit = match[3];
         default: clr_hit = 1'b0;
      endcase
   end

   assign ovf_ev   = tick && !clr_hit && !cnt_wr && (cnt_q == '1);
   assign flag_set = {1'b0, ovf_ev, cap_ev | match};
   assign flag_clr = stat_wr ? (armed_q & ~wdata[FLAG_W-1:0]) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         mode_q   <= '0;
         io_ab_q  <= '0;
         io_cd_q  <= '0;
         ien_q    <= '0;
         status_q <= '0;
         armed_q  <= '0;
         cnt_q    <= '0;
      end else begin
         if (wr_en) begin
            case (addr)
               ADR_CTRL:  ctrl_q  <= wdata;
               ADR_MODE:  mode_q  <= wdata;
               ADR_IO_AB: io_ab_q <= wdata;
               ADR_IO_CD: io_cd_q <= wdata;
               ADR_IEN:   ien_q   <= wdata;
               default: ;
            endcase
         end
         if (cnt_wr) begin
            if (addr == ADR_CNT_HI) cnt_q[WORD_W-1:BYTE_W] <= wdata;
            else                    cnt_q[BYTE_W-1:0]      <= wdata;
         end else if (tick) begin
            cnt_q <= clr_hit ? '0 : cnt_q + 1'b1;
         end
         status_q <= (status_q & ~flag_clr) | flag_set;
         if (stat_wr)      armed_q <= '0;
         else if (stat_rd) armed_q <= armed_q | status_q;
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         ADR_CTRL:   rdata = ctrl_q;
         ADR_MODE:   rdata = mode_q;
         ADR_IO_AB:  rdata = io_ab_q;
         ADR_IO_CD:  rdata = io_cd_q;
         ADR_IEN:    rdata = ien_q;
         ADR_STAT:   rdata = {{(BYTE_W-FLAG_W){1'b0}}, status_q};
         ADR_CNT_HI: rdata = cnt_q[WORD_W-1:BYTE_W];
         ADR_CNT_LO: rdata = cnt_q[BYTE_W-1:0];
         default: begin
            for (int i = 0; i < NUM_SLOT; i++) begin
               if (addr == ADR_SLOT0 + 4'(2 * i))     rdata = slot_val[i][WORD_W-1:BYTE_W];
               if (addr == ADR_SLOT0 + 4'(2 * i + 1)) rdata = slot_val[i][BYTE_W-1:0];
            end
         end
      endcase
   end

   assign irq = |(status_q & ien_q[FLAG_W-1:0]);

   a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_wr) |=> $stable(cnt_q));
   a_r3_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !clr_hit && !cnt_wr && cnt_q == '1) |=> status_q[OVF_BIT]);
   a_r4_clear_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && clr_hit && !cnt_wr) |=> (cnt_q == '0));
   a_r6_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_wr |=> ((status_q & $past(status_q)) == $past(status_q)));
   a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q[FLAG_W-1:0] == '0) |-> !irq);
   a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADR_CNT_LO) |=> (cnt_q[BYTE_W-1:0] == $past(wdata)));
endmodule

// File: tb/cmp_timer_channel_bench.sv
`timescale 1ns/100ps
module cmp_timer_channel_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] run_vec = '0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [3:0] cap_in = '0;
   logic [3:0] cmp_pin;
   logic       irq;

   int    n_cmp = 0, n_bad = 0, cycles = 0;
   bit    done = 0;
   string phase = "R1";

   always #2.5 clk = ~clk;

   cmp_timer_channel u_cmp_timer_channel (
      .clk(clk), .rst_n(rst_n), .run_vec(run_vec), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .cap_in(cap_in),
      .cmp_pin(cmp_pin), .irq(irq));

   // ---------------- behavioural reference model ----------------
   logic [7:0]  m_ctrl, m_mode, m_ioab, m_iocd, m_ien;
   logic [5:0]  m_stat, m_arm;
   logic [15:0] m_cnt;
   logic [15:0] m_slot [4];
   logic [3:0]  m_pin, m_prev;
   int          m_pc;

   function automatic logic [3:0] m_code(input int i);
      case (i)
         0: return m_ioab[3:0];
         1: return m_ioab[7:4];
         2: return m_iocd[3:0];
         default: return m_iocd[7:4];
      endcase
   endfunction

   function automatic logic [7:0] m_rd(input logic [3:0] a);
      case (a)
         0: return m_ctrl;
         1: return m_mode;
         2: return m_ioab;
         3: return m_iocd;
         4: return m_ien;
         5: return {2'b00, m_stat};
         6: return m_cnt[15:8];
         7: return m_cnt[7:0];
         default: return a[0] ? m_slot[(a - 8) / 2][7:0] : m_slot[(a - 8) / 2][15:8];
      endcase
   endfunction

   always @(posedge clk) begin : mdl
      bit tk, clr, ovf, cw, capm, rise, fall;
      int sel, mask, cd, nc;
      logic [3:0] mt, cev;
      logic [5:0] old_stat;
      if (!rst_n) begin
         m_ctrl = 0; m_mode = 0; m_ioab = 0; m_iocd = 0; m_ien = 0;
         m_stat = 0; m_arm = 0; m_cnt = 0; m_pin = 0; m_prev = 0; m_pc = 0;
         for (int i = 0; i < 4; i++) m_slot[i] = 0;
      end else begin
         sel  = int'(m_ctrl[2:0]);
         mask = (sel < 4) ? ((1 << (2 * sel)) - 1) : 0;
         tk   = run_vec[0] && sel < 4 && ((m_pc & mask) == mask);
         for (int i = 0; i < 4; i++) begin
            cd   = int'(m_code(i));
            capm = (cd >= 8 && cd <= 10);
            rise = cap_in[i] && !m_prev[i];
            fall = !cap_in[i] && m_prev[i];
            cev[i] = (cd == 8 && rise) || (cd == 9 && fall) || (cd == 10 && (rise || fall));
            mt[i]  = tk && !capm && (m_cnt == m_slot[i]);
         end
         case (m_ctrl[7:5])
            1: clr = mt[0];
            2: clr = mt[1];
            5: clr = mt[2];
            6: clr = mt[3];
            default: clr = 0;
         endcase
         cw  = wr_en && (addr == 6 || addr == 7);
         ovf = tk && !clr && !cw && (m_cnt == 16'hFFFF);
         // pins
         for (int i = 0; i < 4; i++) begin
            cd = int'(m_code(i));
            nc = (i % 2) ? int'(wdata[7:4]) : int'(wdata[3:0]);
            if (wr_en && addr == ((i < 2) ? 4'd2 : 4'd3)) begin
               if (nc >= 1 && nc <= 3) m_pin[i] = 1'b0;
               if (nc >= 5 && nc <= 7) m_pin[i] = 1'b1;
            end else if (mt[i] && (cd % 4) != 0 && cd < 8) begin
               if (cd % 4 == 1) m_pin[i] = 1'b0;
               else if (cd % 4 == 2) m_pin[i] = 1'b1;
               else m_pin[i] = !m_pin[i];
            end
         end
         // slots
         for (int i = 0; i < 4; i++) begin
            if (wr_en && addr == 4'(8 + 2 * i))      m_slot[i][15:8] = wdata;
            else if (wr_en && addr == 4'(9 + 2 * i)) m_slot[i][7:0] = wdata;
            else if (cev[i])                         m_slot[i] = m_cnt;
         end
         // status
         old_stat = m_stat;
         if (wr_en && addr == 5) begin
            m_stat = m_stat & ~(m_arm & ~wdata[5:0]);
            m_arm  = 0;
         end else if (rd_en && addr == 5) begin
            m_arm = m_arm | old_stat;
         end
         m_stat = m_stat | {1'b0, ovf, mt | cev};
         // counter
         if (cw) begin
            if (addr == 6) m_cnt[15:8] = wdata; else m_cnt[7:0] = wdata;
         end else if (tk) begin
            m_cnt = clr ? 16'h0 : m_cnt + 16'h1;
         end
         if (wr_en) begin
            case (addr)
               0: m_ctrl = wdata;
               1: m_mode = wdata;
               2: m_ioab = wdata;
               3: m_iocd = wdata;
               4: m_ien  = wdata;
               default: ;
            endcase
         end
         m_pc   = run_vec[0] ? (m_pc + 1) % 64 : 0;
         m_prev = cap_in;
      end
   end

   // ---------------- per-cycle comparison ----------------
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_cmp++;
         if (rdata !== m_rd(addr)) begin
            n_bad++;
            $display("FAIL %s rdata@%0d: actual %h expected %h", phase, addr, rdata, m_rd(addr));
         end
         n_cmp++;
         if (irq !== (|(m_stat & m_ien[5:0]))) begin
            n_bad++;
            $display("FAIL R9 irq: actual %b expected %b", irq, |(m_stat & m_ien[5:0]));
         end
         n_cmp++;
         if (cmp_pin !== m_pin) begin
            n_bad++;
            $display("FAIL R8 cmp_pin: actual %b expected %b", cmp_pin, m_pin);
         end
      end
   end

   // ---------------- directed helpers ----------------
   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); #0.5;
      wr_en = 1; rd_en = 0; addr = a; wdata = d;
      @(negedge clk); #0.5;
      wr_en = 0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] v);
      @(negedge clk); #0.5;
      rd_en = 1; wr_en = 0; addr = a;
      #1 v = rdata;
      @(negedge clk); #0.5;
      rd_en = 0;
   endtask

   task automatic run_for(input int n);
      @(negedge clk); #0.5;
      run_vec[0] = 1'b1;
      repeat (n) @(negedge clk);
      #0.5 run_vec[0] = 1'b0;
   endtask

   task automatic set_cnt(input logic [15:0] v);
      wr(6, v[15:8]);
      wr(7, v[7:0]);
   endtask

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin : stim
      logic [7:0] v, v2;
      logic [31:0] lfsr;
      repeat (4) @(negedge clk);
      #0.5 rst_n = 1'b1;

      phase = "R1";
      for (int a = 0; a < 16; a++) begin
         rd(4'(a), v);
         chk("R1 reset register value", v, 0);
      end
      chk("R1 reset pins", cmp_pin, 0);
      chk("R1 reset irq", irq, 0);

      phase = "R10";
      wr(8, 8'h12); wr(9, 8'h34); wr(1, 8'h05);
      rd(8, v); chk("R10 slot A high byte", v, 8'h12);
      rd(9, v); chk("R10 slot A low byte", v, 8'h34);
      rd(1, v); chk("R10 mode storage", v, 8'h05);

      phase = "R4";
      wr(8, 8'h00); wr(9, 8'h03); wr(0, 8'h20); wr(4, 8'h01);
      run_for(12);
      rd(5, v); chk("R5 compare A flag", v[0], 1);
      chk("R9 irq with A enabled", irq, 1);
      rd(7, v); chk("R4 counter within 0..A", (v <= 3) ? 1 : 0, 1);

      phase = "R6";
      wr(5, 8'hFF);
      rd(4'd5, v); chk("R6 write 1 keeps flag", v[0], 1);
      wr(5, 8'hFF);
      wr(5, 8'h00);
      rd(5, v); chk("R6 write 0 without read keeps flag", v[0], 1);
      wr(5, 8'h3E);
      rd(5, v); chk("R6 read then write 0 clears", v[0], 0);
      chk("R9 irq drops after clear", irq, 0);

      phase = "R3";
      wr(0, 8'h00); set_cnt(16'hFFFF);
      run_for(1);
      rd(6, v); rd(7, v2); chk("R3 wrap to zero", {v, v2}, 0);
      rd(5, v); chk("R3 overflow flag", v[4], 1);
      chk("R9 overflow masked", irq, 0);
      wr(4, 8'h10);
      @(negedge clk); #1 chk("R9 overflow enabled", irq, 1);
      rd(5, v); wr(5, 8'h00); wr(4, 8'h00);

      phase = "R2";
      set_cnt(0); wr(0, 8'h01); run_for(8);
      rd(7, v); chk("R2 divide by 4", v, 2);
      set_cnt(0); wr(0, 8'h02); run_for(32);
      rd(7, v); chk("R2 divide by 16", v, 2);
      set_cnt(0); wr(0, 8'h03); run_for(128);
      rd(7, v); chk("R2 divide by 64", v, 2);
      set_cnt(0); wr(0, 8'h05); run_for(10);
      rd(7, v); chk("R2 code 5 holds counter", v, 0);
      phase = "R11";
      set_cnt(0); wr(0, 8'h11); run_for(8);
      rd(7, v); chk("R11 edge bits ignored", v, 2);

      phase = "R8";
      set_cnt(0); wr(0, 8'h20); wr(9, 8'h03); wr(11, 8'h02);
      wr(2, 8'h53);
      chk("R8 code 3 initial low", cmp_pin[0], 0);
      chk("R8 code 5 initial high", cmp_pin[1], 1);
      run_for(4);
      chk("R8 toggle on A match", cmp_pin[0], 1);
      chk("R8 clear on B match", cmp_pin[1], 0);

      phase = "R7";
      rd(5, v); wr(5, 8'h00);
      wr(3, 8'h08); set_cnt(16'h0123);
      @(negedge clk); #0.5 cap_in = 4'b0100;
      @(negedge clk);
      rd(12, v); rd(13, v2); chk("R7 rising capture value", {v, v2}, 16'h0123);
      rd(5, v); chk("R7 capture flag C", v[2], 1);
      wr(3, 8'h98);
      @(negedge clk); #0.5 cap_in = 4'b1100;
      @(negedge clk);
      rd(5, v); chk("R7 rising edge ignored for falling code", v[3], 0);
      wr(7, 8'h45);
      @(negedge clk); #0.5 cap_in = 4'b0100;
      @(negedge clk);
      rd(14, v); rd(15, v2); chk("R7 falling capture value", {v, v2}, 16'h0145);
      rd(5, v); chk("R7 capture flag D", v[3], 1);

      phase = "R10";
      lfsr = 32'h1ACE_B00C;
      for (int n = 0; n < 4000; n++) begin
         @(negedge clk); #0.5;
         lfsr = lfsr * 32'd1664525 + 32'd1013904223;
         wr_en = (lfsr[25:23] == 3'd0);
         rd_en = !wr_en && lfsr[26];
         addr  = lfsr[31:28];
         wdata = lfsr[15:8];
         if (wr_en && addr == 0) wdata[2] = 1'b0;
         cap_in = lfsr[20:17];
         run_vec[0] = (lfsr[7:5] != 3'd0);
      end
      @(negedge clk); #0.5 wr_en = 0; rd_en = 0;
      repeat (3) @(negedge clk);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule